// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block owns the refresh duty of an EDO DRAM controller. Every refresh it issues is a CAS-before-RAS cycle, so the DRAM's own row counter picks the row and the scheduler never drives an address or the data bus. After reset it stays silent for a programmable power-up pause. It then runs a fixed burst of initialization refresh cycles back to back, and after the last one it raises a ready flag that lets the access controller start normal traffic.

Once ready, an interval counter adds one owed refresh every programmable number of clocks. While anything is owed, a request goes out to the access controller. When the controller parks and grants, the scheduler drives both CAS strobes and RAS itself for one refresh cycle and clears one owed refresh. The controller may postpone refreshes, but only up to a parameterized limit. At that limit the scheduler raises an urgent flag and runs the cycle whether or not a grant is present. WE is held high throughout, so no cycle can be taken as a write or test mode.

All timing is counted in clock cycles. The defaults give a 100 µs pause and one refresh every 15.6 µs at 100 MHz, which covers 1024 rows in 16 ms.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, ras_n, lcas_n, ucas_n and we_n are 1, and init_done, ref_req and ref_urgent are 0.
- R2: For PAUSE_CYC cycles after reset is released, RAS and both CAS strobes stay high. The first CAS fall comes no earlier than PAUSE_CYC cycles after release.
- R3: After the pause, exactly INIT_CYCLES refresh cycles run without any grant. init_done rises T_RP cycles after RAS rises at the end of the last of them, and it then stays high until reset.
- R4: In every refresh cycle, both CAS strobes (active low) fall T_CSR cycles before RAS falls. They stay low for T_CHR cycles after RAS falls, and they are back high before RAS rises.
- R5: RAS stays low for exactly T_RAS cycles per refresh. RAS stays high for at least T_RP cycles between its rise and the next CAS fall.
- R6: we_n is 1 at all times, and lcas_n always equals ucas_n.
- R7: Once init_done rises, one refresh becomes owed every INTERVAL_CYC cycles. ref_req is high whenever at least one refresh is owed, and it first rises exactly INTERVAL_CYC cycles after init_done.
- R8: After initialization, a refresh cycle starts only if ref_gnt or ref_urgent was high in the cycle before CAS falls. While fewer than MAX_POSTPONE refreshes are owed and ref_gnt is low, no cycle runs.
- R9: The owed count never exceeds MAX_POSTPONE. ref_urgent is high exactly when MAX_POSTPONE refreshes are owed, and a cycle then starts without a grant.
- R10: Every owed refresh is served by exactly one refresh cycle, including when a new interval lands in the same cycle that a refresh starts. No refresh cycle runs without one being owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access controller is parked; refresh may take the strobes |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Postpone limit reached; next cycle is forced |
| init_done | output | 1 | Power-up pause and initialization cycles complete |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The interval tick that adds an owed refresh can land in the same clock as a grant that starts a refresh and clears one. In that clock the owed count must hold steady rather than lose or gain one. The bench holds the grant low until three refreshes are owed and then releases it at an offset before the next tick. It sweeps that offset across a range longer than a drain of three cycles, so that some tick lands on a refresh start. The result is judged by a scoreboard: each predicted tick pushes one owed item and each observed RAS fall pops one. The urgent flag must match the scoreboard depth whenever the strobes are idle, and the scoreboard must be empty once the request drops.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_HOLD,
    SQ_LOW,
    SQ_PRE
  } sq_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
  import rfsh_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);

  localparam int MAXT = max4(T_CSR, T_CHR, T_RAS, T_RP);
  localparam int CW   = $clog2(MAXT + 1);

  sq_state_t st;
  logic [CW-1:0] cnt;
  logic ras_q;
  logic cas_q;
  logic last;

  assign last  = (cnt == CW'(0));
  assign idle  = (st == SQ_IDLE);
  assign done  = (st == SQ_PRE) && last;
  assign ras_n = ras_q;
  assign cas_n = cas_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start) begin
            st    <= SQ_SETUP;
            cnt   <= CW'(T_CSR - 1);
            cas_q <= 1'b0;
          end
        end
        SQ_SETUP: begin
          if (last) begin
            st    <= SQ_HOLD;
            cnt   <= CW'(T_CHR - 1);
            ras_q <= 1'b0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SQ_HOLD: begin
          if (last) begin
            st    <= SQ_LOW;
            cnt   <= CW'(T_RAS - T_CHR - 1);
            cas_q <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SQ_LOW: begin
          if (last) begin
            st    <= SQ_PRE;
            cnt   <= CW'(T_RP - 1);
            ras_q <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        SQ_PRE: begin
          if (last) begin
            st <= SQ_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          st    <= SQ_IDLE;
          ras_q <= 1'b1;
          cas_q <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/rfsh_power_up.sv
module rfsh_power_up #(
  parameter int PAUSE_CYC   = 10000,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic seq_idle,
  input  logic seq_done,
  output logic pause_busy,
  output logic init_start,
  output logic init_done
);

  localparam int PCW = $clog2(PAUSE_CYC + 1);
  localparam int ICW = $clog2(INIT_CYCLES + 1);

  logic [PCW-1:0] pcnt;
  logic [ICW-1:0] icnt;
  logic           rdy_q;
  logic           more;

  assign pause_busy = (pcnt != PCW'(PAUSE_CYC));
  assign more       = (icnt != ICW'(INIT_CYCLES));
  assign init_start = !pause_busy && !rdy_q && more && seq_idle;
  assign init_done  = rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      icnt  <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (pause_busy) pcnt <= pcnt + PCW'(1);
      if (!rdy_q && seq_done) begin
        icnt <= icnt + ICW'(1);
        if (icnt == ICW'(INIT_CYCLES - 1)) rdy_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  localparam int TW = $clog2(INTERVAL_CYC + 1);

  logic [TW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == TW'(INTERVAL_CYC - 1));
  assign tick = en && wrap;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + TW'(1);
    end
  end

endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
  parameter int MAX_POSTPONE = 8,
  parameter int PW = $clog2(MAX_POSTPONE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          take,
  output logic [PW-1:0] pending,
  output logic          req,
  output logic          urgent
);

  logic [PW-1:0] cnt;
  logic          full;

  assign full    = (cnt == PW'(MAX_POSTPONE));
  assign pending = cnt;
  assign req     = (cnt != '0);
  assign urgent  = full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick && !take && !full) begin
      cnt <= cnt + PW'(1);
    end else if (take && !tick) begin
      cnt <= cnt - PW'(1);
    end
  end

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int PAUSE_CYC    = 10000,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_POSTPONE = 8,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 1,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic init_done,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic we_n
);

  localparam int PW = $clog2(MAX_POSTPONE + 1);

  logic          seq_idle;
  logic          seq_done;
  logic          seq_cas_n;
  logic          seq_start;
  logic          init_start;
  logic          pause_busy;
  logic          tick;
  logic          norm_start;
  logic [PW-1:0] pending;

  assign norm_start = init_done && seq_idle && ref_req && (ref_gnt || ref_urgent);
  assign seq_start  = init_start || norm_start;

  rfsh_power_up #(
    .PAUSE_CYC  (PAUSE_CYC),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_pwr (
    .clk       (clk),
    .rst       (rst),
    .seq_idle  (seq_idle),
    .seq_done  (seq_done),
    .pause_busy(pause_busy),
    .init_start(init_start),
    .init_done (init_done)
  );

  rfsh_interval #(
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_ivl (
    .clk (clk),
    .rst (rst),
    .en  (init_done),
    .tick(tick)
  );

  rfsh_debt #(
    .MAX_POSTPONE(MAX_POSTPONE),
    .PW          (PW)
  ) u_debt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .take   (norm_start),
    .pending(pending),
    .req    (ref_req),
    .urgent (ref_urgent)
  );

  rfsh_cbr_seq #(
    .T_CSR(T_CSR),
    .T_CHR(T_CHR),
    .T_RAS(T_RAS),
    .T_RP (T_RP)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(seq_start),
    .idle (seq_idle),
    .done (seq_done),
    .ras_n(ras_n),
    .cas_n(seq_cas_n)
  );

  assign lcas_n = seq_cas_n;
  assign ucas_n = seq_cas_n;
  assign we_n   = 1'b1;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int MAX_POSTPONE = 8,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ref_urgent,
  input logic          init_done,
  input logic          ras_n,
  input logic          lcas_n,
  input logic          ucas_n,
  input logic          pause_busy,
  input logic [PW-1:0] pending
);

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!lcas_n && !ucas_n && $past(!lcas_n))); // R4

  AST_CAS_UP_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (lcas_n && ucas_n)); // R4

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    pause_busy |-> (ras_n && lcas_n && ucas_n)); // R2

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R3

  AST_GRANTED_START: assert property (@(posedge clk) disable iff (rst)
    ($fell(lcas_n) && $past(init_done)) |-> $past(ref_gnt || ref_urgent)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pending <= PW'(MAX_POSTPONE)); // R9

  AST_URGENT_IMPLIES_REQ: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> ref_req); // R9

endmodule

bind rfsh_sched rfsh_sched_chk #(
  .MAX_POSTPONE(MAX_POSTPONE),
  .PW          (PW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .init_done (init_done),
  .ras_n     (ras_n),
  .lcas_n    (lcas_n),
  .ucas_n    (ucas_n),
  .pause_busy(pause_busy),
  .pending   (pending)
);

// File: tb/tb_rfsh_sched.sv
module tb_rfsh_sched;

  localparam int PAUSE    = 300;
  localparam int NINIT    = 8;
  localparam int INTERVAL = 100;
  localparam int MAXP     = 8;
  localparam int TCSR     = 2;
  localparam int TCHR     = 2;
  localparam int TRAS     = 6;
  localparam int TRP      = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, init_done, ras_n, lcas_n, ucas_n, we_n;

  always #5 clk = ~clk;

  rfsh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(NINIT), .INTERVAL_CYC(INTERVAL),
    .MAX_POSTPONE(MAXP), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) dut (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .init_done(init_done), .ras_n(ras_n),
    .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int q[$];
  event ev_tick;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sb_push(input int kind);
    q.push_back(kind);
  endtask

  // monitor state
  int nc = 0, n0 = 0, last_rise_nc = 0;
  bit ready_seen = 0, req_seen = 0, first_cas = 1, have_rise = 0, urg_seen = 0;
  bit p_ras = 1, p_cas = 1, p_gnt = 0, p_urg = 0;
  int cas_pre = 0, ras_lo = 0, chr = 0, pre_cnt = 0;
  int init_pops = 0, norm_cycles = 0, forced = 0, pair_bad = 0, urg_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      nc++;
      if (ready_seen && !init_done)
        check(0, "R3 init_done dropped", 0, 1);
      if (!ready_seen && init_done) begin
        ready_seen = 1;
        n0 = nc;
        check(init_pops == NINIT, "R3 init cycle count", init_pops, NINIT);
        check(nc - last_rise_nc == TRP, "R3 ready delay after last RAS rise", nc - last_rise_nc, TRP);
      end else if (ready_seen && ((nc - n0) % INTERVAL) == 0) begin
        sb_push(1);
        -> ev_tick;
      end
      if (ready_seen && ref_req && !req_seen) begin
        req_seen = 1;
        check(nc - n0 == INTERVAL, "R7 first request delay", nc - n0, INTERVAL);
      end
      if (lcas_n !== ucas_n || we_n !== 1'b1) pair_bad++;
      if (ref_urgent) urg_seen = 1;
      // CAS fall
      if (!lcas_n && p_cas) begin
        if (first_cas) begin
          first_cas = 0;
          check(nc > PAUSE, "R2 first CAS after pause", nc, PAUSE + 1);
        end
        if (have_rise) check(pre_cnt >= TRP, "R5 precharge length", pre_cnt, TRP);
        if (init_done) begin
          check(p_gnt || p_urg, "R8 start needs grant or urgent", p_gnt, 1);
          norm_cycles++;
          if (!p_gnt) forced++;
        end
        cas_pre = 0;
      end
      if (!lcas_n && ras_n) cas_pre++;
      // RAS fall
      if (!ras_n && p_ras) begin
        check(cas_pre == TCSR, "R4 CAS lead before RAS", cas_pre, TCSR);
        if (q.size() == 0) begin
          check(0, "R10 refresh cycle with nothing owed", 1, 0);
        end else begin
          int k;
          k = q.pop_front();
          check(k == (init_done ? 1 : 0), "R10 cycle kind", init_done, k);
          if (k == 0) init_pops++;
        end
        ras_lo = 0;
        chr = 0;
      end
      if (!ras_n) begin
        ras_lo++;
        if (!lcas_n) chr++;
      end
      if (lcas_n && !p_cas && !ras_n)
        check(chr == TCHR, "R4 CAS hold after RAS fall", chr, TCHR);
      // RAS rise
      if (ras_n && !p_ras) begin
        check(ras_lo == TRAS, "R5 RAS low width", ras_lo, TRAS);
        check(lcas_n == 1'b1, "R4 CAS high before RAS rise", lcas_n, 1);
        last_rise_nc = nc;
        pre_cnt = 0;
        have_rise = 1;
      end
      if (ras_n) pre_cnt++;
      if (ras_n && lcas_n) begin
        if (ref_urgent !== (ready_seen && q.size() == MAXP)) urg_bad++;
      end
      p_ras = ras_n;
      p_cas = lcas_n;
      p_gnt = ref_gnt;
      p_urg = ref_urgent;
    end
  end

  task automatic set_gnt(input bit v);
    @(posedge clk);
    #1 ref_gnt = v;
  endtask

  task automatic drain();
    set_gnt(1);
    do @(negedge clk); while (ref_req);
    set_gnt(0);
  endtask

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check(ras_n && lcas_n && ucas_n && we_n, "R1 strobes high in reset", {ras_n, lcas_n, ucas_n, we_n}, 15);
    check(!init_done && !ref_req && !ref_urgent, "R1 flags low in reset", {init_done, ref_req, ref_urgent}, 0);
    for (int i = 0; i < NINIT; i++) sb_push(0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(ras_n && lcas_n && !init_done && !ref_req, "R1 idle after reset", {ras_n, lcas_n, init_done, ref_req}, 12);

    wait (ready_seen);
    // R8/R10: steady grant serves each interval
    set_gnt(1);
    repeat (350) @(posedge clk);
    check(norm_cycles == 3, "R8 granted cycles", norm_cycles, 3);
    check(!ref_req, "R7 request cleared after service", ref_req, 0);

    // R8: no grant, below limit -> nothing runs
    set_gnt(0);
    begin
      int base;
      base = norm_cycles;
      repeat (700) @(posedge clk);
      check(norm_cycles == base, "R8 no cycle without grant", norm_cycles - base, 0);
      // R9: reaching the limit forces a cycle
      repeat (300) @(posedge clk);
      check(forced >= 1, "R9 forced cycle count", forced, 1);
      check(urg_seen, "R9 urgent raised at limit", urg_seen, 1);
      check(ref_req, "R9 request held after forced cycle", ref_req, 1);
    end
    drain();

    // R10: sweep grant release against the tick phase
    for (int off = 1; off <= 40; off++) begin
      @(ev_tick);
      @(ev_tick);
      @(ev_tick);
      repeat (INTERVAL - off) @(posedge clk);
      drain();
    end

    set_gnt(1);
    repeat (20) @(posedge clk);
    do @(negedge clk); while (ref_req || !ras_n || !lcas_n);
    check(q.size() == 0, "R10 all owed refreshes served", q.size(), 0);
    check(urg_bad == 0, "R9 urgent tracks owed count", urg_bad, 0);
    check(pair_bad == 0, "R6 WE high and CAS pair equal", pair_bad, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule